// File: doc/BRIEF.md
# Product-Term Cluster Steering Allocator

This block routes groups of product terms to the OR gates of sixteen macrocells. Its 64 product-term inputs are taken in sixteen clusters of four. Each cluster is first reduced to a single OR value. A static two-bit steering code per cluster then sends that value to one macrocell in a sliding window of three: the macrocell below the cluster, the macrocell with the same index, or the macrocell above it. The code can also leave the cluster unused. Each macrocell ORs together whatever clusters are steered to it, so it can collect up to three clusters, which is twelve product terms.

The sixteen macrocells form two segments of eight. Windows stop at each segment boundary, so no cluster ever reaches a macrocell in the other segment. A steering code that points past a segment edge is reported on an error flag, and that cluster contributes nothing. The sums and the error flag are registered once before they reach the outputs.

Top module: `pterm_steer`

## Requirements
- R1: The value of cluster c is the OR of product terms pt_i[4c+3:4c]. Any single one of those four terms, with the others low, is enough to drive the cluster's target high.
- R2: Steering code 2'b10 in cfg_i[2c+1:2c] sends cluster c to macrocell c.
- R3: Code 2'b01 sends cluster c to macrocell c-1, and code 2'b11 sends it to macrocell c+1, whenever that macrocell lies in the same segment of eight.
- R4: Code 2'b00 marks cluster c unused. Its product terms then affect no output, even when they are all high.
- R5: Code 2'b01 on cluster 0 or 8, or code 2'b11 on cluster 7 or 15, is illegal. It sets cfg_err_o, and that cluster drives no macrocell. Legal codes never set cfg_err_o, and no cluster in one segment ever reaches a macrocell in the other.
- R6: A macrocell with no cluster steered to it outputs 0.
- R7: A macrocell ORs all clusters steered to it. When clusters c-1, c and c+1 all target macrocell c, each of the twelve product terms can drive it alone.
- R8: sum_o and cfg_err_o reflect the inputs sampled at the previous rising clock edge. While rst_ni is low, both are 0.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pt_i | input | 64 | Product-term values, four per cluster |
| cfg_i | input | 32 | Steering code, two bits per cluster |
| sum_o | output | 16 | Registered sum-of-products, one per macrocell |
| cfg_err_o | output | 1 | Registered illegal-steering flag |

## Verification
A wrong decode inside a cluster shows at the ports on the first rising edge after the offending code is applied. Either the sum appears on the wrong bit of sum_o, or cfg_err_o rises or falls wrongly. The bench therefore drives one cluster at a time, under every code and with each of its four terms alone, and compares the result one cycle later. A stray window across a segment edge, or an unused cluster that leaks, would light an unexpected macrocell on that same next edge. Background runs with every term high are aimed at exactly that fault.

// File: rtl/pterm_steer_pkg.sv
package pterm_steer_pkg;

  typedef enum logic [1:0] {
    STEER_NONE = 2'b00,
    STEER_DOWN = 2'b01,
    STEER_SELF = 2'b10,
    STEER_UP   = 2'b11
  } steer_e;

  localparam int unsigned STEER_W = 2;

endpackage

// File: rtl/pterm_steer_cluster.sv
module pterm_steer_cluster
  import pterm_steer_pkg::*;
#(
  parameter int unsigned PT_PER_CL = 4,
  parameter int unsigned SEG       = 8,
  parameter int unsigned IDX       = 0,
  parameter int unsigned IDX_W     = 4
) (
  input  logic [PT_PER_CL-1:0] pt_i,
  input  logic [STEER_W-1:0]   steer_i,
  output logic                 val_o,
  output logic                 hit_o,
  output logic [IDX_W-1:0]     tgt_o,
  output logic                 bad_o
);

  localparam bit FIRST  = (IDX % SEG) == 0;
  localparam bit LAST   = (IDX % SEG) == (SEG - 1);
  localparam int DN_IDX = FIRST ? int'(IDX) : int'(IDX) - 1;
  localparam int UP_IDX = LAST  ? int'(IDX) : int'(IDX) + 1;

  steer_e code;

  assign val_o = |pt_i;
  assign code  = steer_e'(steer_i);

  always_comb begin
    hit_o = 1'b0;
    bad_o = 1'b0;
    tgt_o = IDX_W'(IDX);
    unique case (code)
      STEER_NONE: ;
      STEER_SELF: hit_o = 1'b1;
      STEER_DOWN: begin
        if (FIRST) bad_o = 1'b1;
        else begin
          hit_o = 1'b1;
          tgt_o = IDX_W'(DN_IDX);
        end
      end
      STEER_UP: begin
        if (LAST) bad_o = 1'b1;
        else begin
          hit_o = 1'b1;
          tgt_o = IDX_W'(UP_IDX);
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pterm_steer_mc.sv
module pterm_steer_mc #(
  parameter int unsigned IDX   = 0,
  parameter int unsigned IDX_W = 4
) (
  input  logic [2:0]            win_val_i,
  input  logic [2:0]            win_hit_i,
  input  logic [2:0][IDX_W-1:0] win_tgt_i,
  output logic                  sum_o
);

  logic [2:0] match;

  for (genvar k = 0; k < 3; k++) begin : g_slot
    assign match[k] = win_hit_i[k] && (win_tgt_i[k] == IDX_W'(IDX));
  end

  assign sum_o = |(match & win_val_i);

endmodule

// File: rtl/pterm_steer.sv
module pterm_steer
  import pterm_steer_pkg::*;
#(
  parameter int unsigned N_MC      = 16,
  parameter int unsigned PT_PER_CL = 4,
  parameter int unsigned SEG       = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_MC*PT_PER_CL-1:0]    pt_i,
  input  logic [N_MC*STEER_W-1:0]      cfg_i,
  output logic [N_MC-1:0]              sum_o,
  output logic                         cfg_err_o
);

  localparam int unsigned IDX_W = (N_MC > 1) ? $clog2(N_MC) : 1;

  logic [N_MC-1:0]            cl_val;
  logic [N_MC-1:0]            cl_hit;
  logic [N_MC-1:0]            cl_bad;
  logic [N_MC-1:0][IDX_W-1:0] cl_tgt;
  logic [N_MC-1:0]            sum_d;
  logic                       err_d;

  for (genvar c = 0; c < N_MC; c++) begin : g_cl
    pterm_steer_cluster #(
      .PT_PER_CL(PT_PER_CL),
      .SEG      (SEG),
      .IDX      (c),
      .IDX_W    (IDX_W)
    ) u_cl (
      .pt_i   (pt_i[c*PT_PER_CL +: PT_PER_CL]),
      .steer_i(cfg_i[c*STEER_W +: STEER_W]),
      .val_o  (cl_val[c]),
      .hit_o  (cl_hit[c]),
      .tgt_o  (cl_tgt[c]),
      .bad_o  (cl_bad[c])
    );
  end

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    logic [2:0]            w_val;
    logic [2:0]            w_hit;
    logic [2:0][IDX_W-1:0] w_tgt;

    for (genvar k = 0; k < 3; k++) begin : g_win
      localparam int C = int'(m) - 1 + int'(k);
      // window slot exists only inside the macrocell's own segment
      if (C >= 0 && C < int'(N_MC) && (C / int'(SEG)) == (int'(m) / int'(SEG))) begin : g_live
        assign w_val[k] = cl_val[C];
        assign w_hit[k] = cl_hit[C];
        assign w_tgt[k] = cl_tgt[C];
      end else begin : g_dead
        assign w_val[k] = 1'b0;
        assign w_hit[k] = 1'b0;
        assign w_tgt[k] = '0;
      end
    end

    pterm_steer_mc #(
      .IDX  (m),
      .IDX_W(IDX_W)
    ) u_mc (
      .win_val_i(w_val),
      .win_hit_i(w_hit),
      .win_tgt_i(w_tgt),
      .sum_o    (sum_d[m])
    );
  end

  assign err_d = |cl_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o     <= '0;
      cfg_err_o <= 1'b0;
    end else begin
      sum_o     <= sum_d;
      cfg_err_o <= err_d;
    end
  end

endmodule

// File: rtl/pterm_steer_chk.sv
module pterm_steer_chk #(
  parameter int unsigned N_MC      = 16,
  parameter int unsigned PT_PER_CL = 4,
  parameter int unsigned SEG       = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [N_MC*PT_PER_CL-1:0] pt_i,
  input logic [N_MC*2-1:0]         cfg_i,
  input logic [N_MC-1:0]           sum_o,
  input logic                      cfg_err_o
);

  // R8
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (sum_o == '0 && !cfg_err_o));

  // R6
  empty_cfg_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i == '0) |=> (sum_o == '0 && !cfg_err_o));

  // R1
  no_terms_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pt_i == '0) |=> (sum_o == '0));

  // R5
  low_edge_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[1:0] == 2'b01) |=> cfg_err_o);

  // R5
  high_edge_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[2*SEG-1 -: 2] == 2'b11) |=> cfg_err_o);

  // R5
  segment_isolation_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pt_i[SEG*PT_PER_CL-1:0] == '0) |=> (sum_o[SEG-1:0] == '0));

  // R2
  all_self_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i == {N_MC{2'b10}} && pt_i == '1) |=> (sum_o == '1 && !cfg_err_o));

endmodule

bind pterm_steer pterm_steer_chk #(
  .N_MC     (N_MC),
  .PT_PER_CL(PT_PER_CL),
  .SEG      (SEG)
) u_chk (.*);

// File: tb/pterm_steer_tb.sv
`timescale 1ns/1ps
module pterm_steer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [63:0] pt_r = '0;
  logic [31:0] cfg_r = '0;
  logic [15:0] sum_w;
  logic        err_w;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pterm_steer u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .pt_i     (pt_r),
    .cfg_i    (cfg_r),
    .sum_o    (sum_w),
    .cfg_err_o(err_w)
  );

  function automatic logic [16:0] model(input logic [63:0] pt, input logic [31:0] cfg);
    logic [15:0] s = '0;
    logic        e = 1'b0;
    for (int c = 0; c < 16; c++) begin
      int   code = int'(cfg[2*c +: 2]);
      logic v    = |pt[4*c +: 4];
      int   pos  = c % 8;
      if (code == 1 && pos == 0) e = 1'b1;
      else if (code == 3 && pos == 7) e = 1'b1;
      else if (code != 0 && v) s[c + code - 2] = 1'b1;
    end
    return {e, s};
  endfunction

  task automatic cmp(input logic [16:0] exp, input string tag);
    n_run++;
    if ({err_w, sum_w} !== exp) begin
      n_fail++;
      $display("FAIL %s: got err=%0b sum=%h, expected err=%0b sum=%h",
               tag, err_w, sum_w, exp[16], exp[15:0]);
    end
  endtask

  task automatic run(input logic [63:0] pt, input logic [31:0] cfg, input string tag);
    @(negedge clk);
    pt_r  = pt;
    cfg_r = cfg;
    @(negedge clk);
    cmp(model(pt, cfg), tag);
  endtask

  function automatic string sweep_tag(input int c, input int code);
    if (code == 0) return "R4";
    if (code == 2) return "R2";
    if ((code == 1 && c % 8 == 0) || (code == 3 && c % 8 == 7)) return "R5";
    return "R3";
  endfunction

  initial begin
    logic [31:0] lf;
    logic [63:0] prev_pt;
    logic [31:0] prev_cfg;
    #1 rst_n = 1'b0;
    pt_r  = '1;
    cfg_r = {16{2'b10}};
    repeat (3) @(negedge clk);
    cmp(17'h0, "R8 reset");
    rst_n = 1'b1;

    run('0, '0, "R6 all unused");

    // single cluster, every code, each term alone
    for (int c = 0; c < 16; c++)
      for (int code = 0; code < 4; code++)
        for (int b = 0; b < 4; b++)
          run(64'd1 << (4*c + b), 32'(code) << (2*c), {sweep_tag(c, code), " R1"});

    // all other terms high but unused: only the configured cluster may show
    for (int c = 0; c < 16; c++)
      for (int code = 0; code < 4; code++)
        run('1, 32'(code) << (2*c), {sweep_tag(c, code), " R4 R6 background"});

    // twelve terms into macrocell 4 from clusters 3,4,5
    for (int t = 12; t < 24; t++)
      run(64'd1 << t, (32'b11 << 6) | (32'b10 << 8) | (32'b01 << 10), "R7 twelve terms");
    run('0, (32'b11 << 6) | (32'b10 << 8) | (32'b01 << 10), "R7 none active");
    run('1, 32'h5555_5555, "R5 all down");
    run('1, 32'hFFFF_FFFF, "R5 all up");
    run('1, {16{2'b10}}, "R2 all self");

    lf = 32'hACE1_2345;
    for (int i = 0; i < 60; i++) begin
      logic [63:0] p;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      p[31:0] = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      p[63:32] = lf & {lf[15:0], lf[31:16]};
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      run(p, lf, "R7 mixed");
    end

    // latency: new inputs do not show before the next rising edge
    prev_pt  = 64'h0000_0000_0000_00F0;
    prev_cfg = 32'b10 << 2;
    run(prev_pt, prev_cfg, "R8 setup");
    @(negedge clk);
    pt_r  = '1;
    cfg_r = 32'h5555_5554;
    #1 cmp(model(prev_pt, prev_cfg), "R8 hold before edge");
    @(negedge clk);
    cmp(model('1, 32'h5555_5554), "R8 after edge");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule